// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-visible register bank of a two-channel DMA engine. Channel 0 moves data from memory to a stream and channel 1 moves data from a stream to memory. A simple 32-bit word bus reaches, for each channel, a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. The block holds run/stop, a soft-reset request that stays pending until software reads control back, the halted and idle flags, and three interrupt flags that software clears by writing ones.

The descriptor engine and the completion-coalescing counters live outside. The engine reports events (halt, idle, interrupt causes, next-descriptor loads) through pulse inputs. The live coalescing count and delay-timer count arrive as inputs and show up in the upper bytes of a status read. The bank drives the run level, the threshold fields, a counter-reload pulse, a soft-reset pulse, one interrupt line per channel, a start pulse when the memory-to-stream tail pointer is written, and a ready-notify pulse on any write to the stream-to-memory channel, which lets a stalled stream source retry.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, control reads 0x00010000 on both channels, status reads 0x00000001 in its low 16 bits (halted only), and both interrupt lines are low.
- R2: The channel index is bit 0 of (offset / 0x30). Inside a 0x30-byte window, control is at 0x00, status at 0x04, current descriptor at 0x08 and tail descriptor at 0x10, so offset 0x68 reaches channel 0 and 0x98 reaches channel 1. Read data appears on the cycle after the read strobe.
- R3: A control write stores the written word with bit 1 (tail mode) forced to 1 and bit 2 (soft reset) kept if it was already set. It pulses the counter reload for that channel on the next cycle. The threshold output is bits 23:16 and the delay output is bits 31:24.
- R4: If the resulting bit 2 is 1, the channel resets: control becomes 0x00010006, the status low half becomes 0x0001, run (bit 0) stays 0, and the soft-reset output pulses for one cycle.
- R5: A control write with bit 0 set and a resulting bit 2 of 0 clears status bits 0 (halted) and 1 (idle), and the run output goes high.
- R6: A control read returns the stored value with bit 2 cleared and clears bit 2 in the register.
- R7: A status read returns the stored bits 15:0, the live coalescing count in bits 23:16 and the live delay-timer count in bits 31:24.
- R8: Status bits 14:12 are write-one-to-clear. The other low bits take the written value. Engine event inputs set halted (bit 0), idle (bit 1) and the interrupt bits 14:12, and a set wins over a clear in the same cycle.
- R9: A channel's interrupt line is high exactly when (status bits 14:12) AND (control bits 14:12) is nonzero.
- R10: A tail-pointer write stores the pointer and clears idle. On channel 0 only, it raises the start pulse for the next cycle.
- R11: Any write to channel 1 raises the ready-notify pulse for the next cycle. A channel 0 write does not.
- R12: The current-descriptor pointer takes bus writes, and otherwise takes the engine value on a load pulse. The other window offsets (0x0C, 0x14 to 0x2C) are plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| live_cnt | input | 2*CNT_W | Live coalescing count, channel 0 in the low byte |
| live_dly | input | 2*CNT_W | Live delay-timer count, channel 0 in the low byte |
| evt_halt | input | 2 | Engine sets halted, per channel |
| evt_idle | input | 2 | Engine sets idle, per channel |
| evt_irq | input | 6 | Engine sets interrupt bits 14:12, three per channel |
| cd_load | input | 2 | Engine loads the current-descriptor pointer |
| cd_next | input | 64 | Next-descriptor values, channel 0 in the low word |
| irq | output | 2 | Interrupt line per channel |
| run | output | 2 | Control run bit per channel |
| soft_rst | output | 2 | One-cycle soft-reset pulse per channel |
| cnt_reload | output | 2 | One-cycle counter-reload pulse per channel |
| cnt_thresh | output | 2*CNT_W | Completion threshold fields |
| dly_thresh | output | 2*CNT_W | Delay-timer fields |
| cur_desc | output | 64 | Current-descriptor pointers |
| tail_desc | output | 64 | Tail-descriptor pointers |
| tx_kick | output | 1 | Start pulse after a channel 0 tail write |
| rx_notify | output | 1 | Ready-notify pulse after a channel 1 write |

## Verification
The hardest state to reach is a soft reset that is still pending: only a read of control clears it, so the bench writes control with the run and reset bits and then writes run again before any read. It then checks that the second write resets the channel again and leaves it halted. Only after a control read does a run write take effect. A second hard case is an engine interrupt event that lands in the same cycle as a write-one-to-clear of that bit. The bench drives both strobes together on one falling edge to show that the set wins.

// File: rtl/dma_regs_pkg.sv
// Package: shared constants for the DMA channel register bank.
// Holds word indices inside a channel window, control/status bit positions
// and reset values. Assumes a 32-bit data path.
package dma_regs_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned CNT_W       = 8;
    localparam int unsigned WIN_BYTES   = 48;
    localparam int unsigned WIN_WORDS   = WIN_BYTES / 4;

    // Word indices inside a channel window
    localparam int unsigned WORD_CTRL   = 0;
    localparam int unsigned WORD_STAT   = 1;
    localparam int unsigned WORD_CUR    = 2;
    localparam int unsigned WORD_TAIL   = 4;

    // Control bits
    localparam int unsigned CTRL_RUN    = 0;
    localparam int unsigned CTRL_MODE   = 1;
    localparam int unsigned CTRL_SRST   = 2;
    localparam int unsigned THR_LSB     = 16;
    localparam int unsigned DLY_LSB     = 24;

    // Status bits
    localparam int unsigned STAT_HALT   = 0;
    localparam int unsigned STAT_IDLE   = 1;
    localparam int unsigned IRQ_LSB     = 12;
    localparam int unsigned IRQ_W       = 3;
    localparam int unsigned STAT_W      = 16;

    localparam logic [DATA_W-1:0] CTRL_MODE_MASK = 32'h0000_0002;
    localparam logic [DATA_W-1:0] CTRL_SRST_MASK = 32'h0000_0004;
    localparam logic [DATA_W-1:0] CTRL_RST_VAL   = 32'h0001_0000;
    localparam logic [DATA_W-1:0] CTRL_SOFT_VAL  = 32'h0001_0006;
    localparam logic [STAT_W-1:0] STAT_RST_VAL   = 16'h0001;
endpackage

// File: rtl/dma_addr_decode.sv
// Module: dma_addr_decode
// Splits a byte offset into a channel index (bit 0 of offset / window size)
// and a word index inside the window. Purely combinational.
// Assumes word-aligned offsets and ADDR_W >= WIDX_W + 2.
module dma_addr_decode #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WIN_BYTES = 48,
    parameter int unsigned WIDX_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              chan,
    output logic [WIDX_W-1:0] word
);
    localparam logic [ADDR_W-1:0] WIN_L = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] win_num;
    logic [ADDR_W-1:0] win_rem;
    logic              unused_bits;

    // Divide the offset into window number and remainder
    always_comb begin
        win_num = addr / WIN_L;
        win_rem = addr - (win_num * WIN_L);
    end

    assign chan        = win_num[0];
    assign word        = win_rem[WIDX_W+1:2];
    assign unused_bits = ^{win_num[ADDR_W-1:1], win_rem[ADDR_W-1:WIDX_W+2], win_rem[1:0]};
endmodule

// File: rtl/dma_chan_bank.sv
// Module: dma_chan_bank
// Register set of one DMA channel: control, status, current and tail
// descriptor pointers, plus spare storage words. Produces the interrupt
// line, run level, threshold fields and one-cycle reload/reset/start pulses.
// Assumes the caller qualifies wr_sel/rd_sel with the channel decode and
// never asserts both in the same cycle for the same word.
module dma_chan_bank
    import dma_regs_pkg::*;
#(
    parameter bit          IS_TX  = 1'b0,
    parameter int unsigned WIDX_W = 4,
    parameter int unsigned WORDS  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic              rd_sel,
    input  logic [WIDX_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [CNT_W-1:0]  live_dly,
    input  logic              evt_halt,
    input  logic              evt_idle,
    input  logic [IRQ_W-1:0]  evt_irq,
    input  logic              cd_load,
    input  logic [DATA_W-1:0] cd_next,
    output logic [DATA_W-1:0] rd_val,
    output logic              irq,
    output logic              run,
    output logic              soft_rst,
    output logic              cnt_reload,
    output logic [CNT_W-1:0]  cnt_thresh,
    output logic [CNT_W-1:0]  dly_thresh,
    output logic [DATA_W-1:0] cur_desc,
    output logic [DATA_W-1:0] tail_desc,
    output logic              kick
);
    localparam int unsigned SLOTS = 1 << WIDX_W;
    localparam logic [WIDX_W-1:0] W_CTRL = WIDX_W'(WORD_CTRL);
    localparam logic [WIDX_W-1:0] W_STAT = WIDX_W'(WORD_STAT);
    localparam logic [WIDX_W-1:0] W_CUR  = WIDX_W'(WORD_CUR);
    localparam logic [WIDX_W-1:0] W_TAIL = WIDX_W'(WORD_TAIL);

    logic [DATA_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_n;
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] tail_q;
    logic [DATA_W-1:0] ctrl_merged;
    logic              rst_req;
    logic              wr_ctrl, wr_stat, wr_cur, wr_tail, rd_ctrl;
    logic              soft_rst_q, reload_q;
    logic [DATA_W-1:0] spare_rd [SLOTS];

    // Word strobes for this channel
    always_comb begin
        wr_ctrl = wr_sel && (word == W_CTRL);
        wr_stat = wr_sel && (word == W_STAT);
        wr_cur  = wr_sel && (word == W_CUR);
        wr_tail = wr_sel && (word == W_TAIL);
        rd_ctrl = rd_sel && (word == W_CTRL);
    end

    // Control word as it would be stored: mode forced, pending reset kept
    always_comb begin
        ctrl_merged = wdata | CTRL_MODE_MASK | (ctrl_q & CTRL_SRST_MASK);
        rst_req     = ctrl_merged[CTRL_SRST];
    end

    // Control register: soft reset, plain store, or reset-bit clear on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST_VAL;
        end else if (wr_ctrl) begin
            ctrl_q <= rst_req ? CTRL_SOFT_VAL : ctrl_merged;
        end else if (rd_ctrl) begin
            ctrl_q <= ctrl_q & ~CTRL_SRST_MASK;
        end
    end

    // Next status: software effects first, engine events OR-ed in last
    always_comb begin
        stat_n = stat_q;
        if (wr_ctrl) begin
            if (rst_req) begin
                stat_n = STAT_RST_VAL;
            end else if (wdata[CTRL_RUN]) begin
                stat_n[STAT_HALT] = 1'b0;
                stat_n[STAT_IDLE] = 1'b0;
            end
        end
        if (wr_stat) begin
            stat_n = {wdata[STAT_W-1:IRQ_LSB+IRQ_W],
                      stat_q[IRQ_LSB+:IRQ_W] & ~wdata[IRQ_LSB+:IRQ_W],
                      wdata[IRQ_LSB-1:0]};
        end
        if (wr_tail) begin
            stat_n[STAT_IDLE] = 1'b0;
        end
        stat_n[STAT_HALT]      = stat_n[STAT_HALT] | evt_halt;
        stat_n[STAT_IDLE]      = stat_n[STAT_IDLE] | evt_idle;
        stat_n[IRQ_LSB+:IRQ_W] = stat_n[IRQ_LSB+:IRQ_W] | evt_irq;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_RST_VAL;
        else        stat_q <= stat_n;
    end

    // Current-descriptor pointer: bus write wins over engine load
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_q <= '0;
        else if (wr_cur)  cur_q <= wdata;
        else if (cd_load) cur_q <= cd_next;
    end

    // Tail-descriptor pointer
    always_ff @(posedge clk) begin
        if (!rst_n)       tail_q <= '0;
        else if (wr_tail) tail_q <= wdata;
    end

    // One-cycle pulses that follow a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_rst_q <= 1'b0;
            reload_q   <= 1'b0;
        end else begin
            soft_rst_q <= wr_ctrl && rst_req;
            reload_q   <= wr_ctrl;
        end
    end

    // Start pulse exists only on the memory-to-stream channel
    generate
        if (IS_TX) begin : g_kick
            logic kick_q;
            // Pulse after a tail-pointer write
            always_ff @(posedge clk) begin
                if (!rst_n) kick_q <= 1'b0;
                else        kick_q <= wr_tail;
            end
            assign kick = kick_q;

            assert_kick_R10: assert property (@(posedge clk) disable iff (!rst_n)
                kick_q |-> $past(wr_sel && (word == W_TAIL)));
        end else begin : g_nokick
            assign kick = 1'b0;
        end
    endgenerate

    // Spare storage words for the offsets without a defined meaning
    generate
        for (genvar w = 0; w < SLOTS; w++) begin : g_spare
            if (w >= WORDS || w == WORD_CTRL || w == WORD_STAT ||
                w == WORD_CUR || w == WORD_TAIL) begin : g_none
                assign spare_rd[w] = '0;
            end else begin : g_store
                logic [DATA_W-1:0] spare_q;
                // Plain storage word
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        spare_q <= '0;
                    else if (wr_sel && (word == WIDX_W'(w)))
                        spare_q <= wdata;
                end
                assign spare_rd[w] = spare_q;
            end
        end
    endgenerate

    // Read value of the addressed word
    always_comb begin
        case (word)
            W_CTRL:  rd_val = ctrl_q & ~CTRL_SRST_MASK;
            W_STAT:  rd_val = {live_dly, live_cnt, stat_q};
            W_CUR:   rd_val = cur_q;
            W_TAIL:  rd_val = tail_q;
            default: rd_val = spare_rd[word];
        endcase
    end

    assign irq        = |(stat_q[IRQ_LSB+:IRQ_W] & ctrl_q[IRQ_LSB+:IRQ_W]);
    assign run        = ctrl_q[CTRL_RUN];
    assign soft_rst   = soft_rst_q;
    assign cnt_reload = reload_q;
    assign cnt_thresh = ctrl_q[THR_LSB+:CNT_W];
    assign dly_thresh = ctrl_q[DLY_LSB+:CNT_W];
    assign cur_desc   = cur_q;
    assign tail_desc  = tail_q;

    assert_mode_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_sel && (word == W_CTRL)) |-> ctrl_q[CTRL_MODE]);

    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ctrl && rst_req) |-> (stat_q[STAT_HALT] && !ctrl_q[CTRL_RUN] && soft_rst_q));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_sel && !wr_sel && (word == W_CTRL)) |-> !ctrl_q[CTRL_SRST]);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_sel && (word == W_STAT) && wdata[IRQ_LSB] && !evt_irq[0]) |-> !stat_q[IRQ_LSB]);

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_irq[0]) |-> stat_q[IRQ_LSB]);
endmodule

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs (top)
// Two-channel DMA control/status register bank on a 32-bit word bus.
// Channel 0 is memory-to-stream, channel 1 stream-to-memory. Registers the
// read data one cycle after the read strobe and pulses rx_notify after any
// channel 1 write. Assumes word-aligned 32-bit accesses.
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [2*CNT_W-1:0]   live_cnt,
    input  logic [2*CNT_W-1:0]   live_dly,
    input  logic [1:0]           evt_halt,
    input  logic [1:0]           evt_idle,
    input  logic [2*IRQ_W-1:0]   evt_irq,
    input  logic [1:0]           cd_load,
    input  logic [2*DATA_W-1:0]  cd_next,
    output logic [1:0]           irq,
    output logic [1:0]           run,
    output logic [1:0]           soft_rst,
    output logic [1:0]           cnt_reload,
    output logic [2*CNT_W-1:0]   cnt_thresh,
    output logic [2*CNT_W-1:0]   dly_thresh,
    output logic [2*DATA_W-1:0]  cur_desc,
    output logic [2*DATA_W-1:0]  tail_desc,
    output logic                 tx_kick,
    output logic                 rx_notify
);
    localparam int unsigned NCH    = 2;
    localparam int unsigned WIDX_W = $clog2(WIN_WORDS);

    logic              sel_chan;
    logic [WIDX_W-1:0] sel_word;
    logic [DATA_W-1:0] ch_rd [NCH];
    logic [NCH-1:0]    ch_kick;
    logic [DATA_W-1:0] rdata_q;
    logic              notify_q;
    logic              unused_kick;

    dma_addr_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BYTES (WIN_BYTES),
        .WIDX_W    (WIDX_W)
    ) i_decode (
        .addr (bus_addr),
        .chan (sel_chan),
        .word (sel_word)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            dma_chan_bank #(
                .IS_TX  (c == 0),
                .WIDX_W (WIDX_W),
                .WORDS  (WIN_WORDS)
            ) i_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_sel     (bus_wr && (sel_chan == 1'(c))),
                .rd_sel     (bus_rd && (sel_chan == 1'(c))),
                .word       (sel_word),
                .wdata      (bus_wdata),
                .live_cnt   (live_cnt[c*CNT_W +: CNT_W]),
                .live_dly   (live_dly[c*CNT_W +: CNT_W]),
                .evt_halt   (evt_halt[c]),
                .evt_idle   (evt_idle[c]),
                .evt_irq    (evt_irq[c*IRQ_W +: IRQ_W]),
                .cd_load    (cd_load[c]),
                .cd_next    (cd_next[c*DATA_W +: DATA_W]),
                .rd_val     (ch_rd[c]),
                .irq        (irq[c]),
                .run        (run[c]),
                .soft_rst   (soft_rst[c]),
                .cnt_reload (cnt_reload[c]),
                .cnt_thresh (cnt_thresh[c*CNT_W +: CNT_W]),
                .dly_thresh (dly_thresh[c*CNT_W +: CNT_W]),
                .cur_desc   (cur_desc[c*DATA_W +: DATA_W]),
                .tail_desc  (tail_desc[c*DATA_W +: DATA_W]),
                .kick       (ch_kick[c])
            );
        end
    endgenerate

    // Registered read data from the addressed channel
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= ch_rd[sel_chan];
    end

    // Ready-notify pulse after any write to the stream-to-memory channel
    always_ff @(posedge clk) begin
        if (!rst_n) notify_q <= 1'b0;
        else        notify_q <= bus_wr && sel_chan;
    end

    assign bus_rdata   = rdata_q;
    assign rx_notify   = notify_q;
    assign tx_kick     = ch_kick[0];
    assign unused_kick = ch_kick[1];

    assert_notify_R11: assert property (@(posedge clk) disable iff (!rst_n)
        notify_q |-> $past(bus_wr && sel_chan));

    assert_no_rx_kick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |-> $past(bus_wr && !sel_chan));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] live_cnt = '0, live_dly = '0;
    logic [1:0]  evt_halt = '0, evt_idle = '0, cd_load = '0;
    logic [5:0]  evt_irq = '0;
    logic [63:0] cd_next = '0;
    logic [1:0]  irq, run, soft_rst, cnt_reload;
    logic [15:0] cnt_thresh, dly_thresh;
    logic [63:0] cur_desc, tail_desc;
    logic        tx_kick, rx_notify;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_cnt(live_cnt), .live_dly(live_dly), .evt_halt(evt_halt),
        .evt_idle(evt_idle), .evt_irq(evt_irq), .cd_load(cd_load),
        .cd_next(cd_next), .irq(irq), .run(run), .soft_rst(soft_rst),
        .cnt_reload(cnt_reload), .cnt_thresh(cnt_thresh), .dly_thresh(dly_thresh),
        .cur_desc(cur_desc), .tail_desc(tail_desc), .tx_kick(tx_kick),
        .rx_notify(rx_notify)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one word; returns just after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tk_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 ch0 control", v, 32'h0001_0000);
        rd(8'h04, v); check("R1 ch0 status", v, 32'h0000_0001);
        rd(8'h30, v); check("R1 ch1 control", v, 32'h0001_0000);
        rd(8'h34, v); check("R1 ch1 status", v, 32'h0000_0001);
        check("R1 irq low", {30'd0, irq}, 32'd0);
    endtask

    task automatic tk_map();
        logic [31:0] v;
        wr(8'h08, 32'hA000_0100);
        wr(8'h38, 32'hB000_0200);
        rd(8'h08, v); check("R2 ch0 current", v, 32'hA000_0100);
        rd(8'h38, v); check("R2 ch1 current", v, 32'hB000_0200);
        rd(8'h68, v); check("R2 alias 0x68 to ch0", v, 32'hA000_0100);
        rd(8'h98, v); check("R2 alias 0x98 to ch1", v, 32'hB000_0200);
        check("R2 cur_desc port", cur_desc[31:0], 32'hA000_0100);
    endtask

    task automatic tk_ctrl();
        logic [31:0] v;
        wr(8'h00, 32'h2A13_0000);
        check("R3 reload pulse", {31'd0, cnt_reload[0]}, 32'd1);
        @(negedge clk);
        check("R3 reload one cycle", {31'd0, cnt_reload[0]}, 32'd0);
        check("R3 threshold field", {24'd0, cnt_thresh[7:0]}, 32'h13);
        check("R3 delay field", {24'd0, dly_thresh[7:0]}, 32'h2A);
        rd(8'h00, v); check("R3 mode bit forced", v, 32'h2A13_0002);
    endtask

    task automatic tk_run();
        logic [31:0] v;
        wr(8'h00, 32'h0001_0001);
        rd(8'h04, v); check("R5 halted and idle cleared", v, 32'h0000_0000);
        check("R5 run output", {31'd0, run[0]}, 32'd1);
    endtask

    task automatic tk_status();
        logic [31:0] v;
        live_cnt = 16'h775A; live_dly = 16'h88C3;
        rd(8'h04, v); check("R7 ch0 live fields", v, 32'hC35A_0000);
        rd(8'h34, v); check("R7 ch1 live fields", v, 32'h8877_0001);
        live_cnt = '0; live_dly = '0;
    endtask

    task automatic tk_w1c();
        logic [31:0] v;
        @(negedge clk); evt_irq = 6'b000_011;
        @(negedge clk); evt_irq = '0;
        rd(8'h04, v); check("R8 events set bits", v, 32'h0000_3000);
        wr(8'h04, 32'h0000_1000);
        rd(8'h04, v); check("R8 write-one clears only bit 12", v, 32'h0000_2000);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_2000; evt_irq = 6'b000_010;
        @(negedge clk);
        bus_wr = 1'b0; evt_irq = '0;
        rd(8'h04, v); check("R8 set wins over clear", v, 32'h0000_2000);
    endtask

    task automatic tk_irq();
        check("R9 irq masked", {31'd0, irq[0]}, 32'd0);
        wr(8'h00, 32'h0001_2001);
        check("R9 irq enabled", {31'd0, irq[0]}, 32'd1);
        check("R9 other channel quiet", {31'd0, irq[1]}, 32'd0);
        wr(8'h04, 32'h0000_2000);
        check("R9 irq after clear", {31'd0, irq[0]}, 32'd0);
    endtask

    task automatic tk_tail();
        logic [31:0] v;
        @(negedge clk); evt_idle = 2'b01;
        @(negedge clk); evt_idle = '0;
        rd(8'h04, v); check("R10 idle set by engine", v, 32'h0000_0002);
        wr(8'h10, 32'h0000_1000);
        check("R10 ch0 start pulse", {31'd0, tx_kick}, 32'd1);
        @(negedge clk);
        check("R10 start pulse one cycle", {31'd0, tx_kick}, 32'd0);
        rd(8'h04, v); check("R10 idle cleared", v, 32'h0000_0000);
        rd(8'h10, v); check("R10 tail stored", v, 32'h0000_1000);
        wr(8'h40, 32'h0000_2000);
        check("R10 no start on ch1", {31'd0, tx_kick}, 32'd0);
        check("R10 ch1 tail port", tail_desc[63:32], 32'h0000_2000);
    endtask

    task automatic tk_notify();
        wr(8'h3C, 32'h5555_AAAA);
        check("R11 notify after ch1 write", {31'd0, rx_notify}, 32'd1);
        @(negedge clk);
        check("R11 notify one cycle", {31'd0, rx_notify}, 32'd0);
        wr(8'h2C, 32'h1234_5678);
        check("R11 no notify for ch0", {31'd0, rx_notify}, 32'd0);
    endtask

    task automatic tk_srst();
        logic [31:0] v;
        wr(8'h30, 32'h0000_0005);
        check("R4 soft reset pulse", {31'd0, soft_rst[1]}, 32'd1);
        check("R4 run ignored", {31'd0, run[1]}, 32'd0);
        rd(8'h34, v); check("R4 status halted", v, 32'h0000_0001);
        wr(8'h30, 32'h0000_0001);
        check("R4 pending reset repeats", {31'd0, soft_rst[1]}, 32'd1);
        rd(8'h34, v); check("R4 still halted", v, 32'h0000_0001);
        rd(8'h30, v); check("R6 read hides reset bit", v, 32'h0001_0002);
        rd(8'h30, v); check("R6 reset bit cleared", v, 32'h0001_0002);
        wr(8'h30, 32'h0000_0001);
        check("R6 no reset after read", {31'd0, soft_rst[1]}, 32'd0);
        rd(8'h34, v); check("R5 ch1 running", v, 32'h0000_0000);
        rd(8'h30, v); check("R3 ch1 control stored", v, 32'h0000_0003);
    endtask

    task automatic tk_cd();
        logic [31:0] v;
        @(negedge clk); cd_load = 2'b10; cd_next = {32'hDEAD_0040, 32'hFFFF_FFFF};
        @(negedge clk); cd_load = '0;
        rd(8'h38, v); check("R12 engine load ch1", v, 32'hDEAD_0040);
        rd(8'h08, v); check("R12 ch0 untouched", v, 32'hA000_0100);
        rd(8'h2C, v); check("R12 spare ch0", v, 32'h1234_5678);
        rd(8'h3C, v); check("R12 spare ch1", v, 32'h5555_AAAA);
        rd(8'h5C, v); check("R12 spare ch1 top", v, 32'h0000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tk_reset();
        tk_map();
        tk_ctrl();
        tk_run();
        tk_status();
        tk_w1c();
        tk_irq();
        tk_tail();
        tk_notify();
        tk_srst();
        tk_cd();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule